// File: doc/BRIEF.md
# TDM Serial Audio Transmitter with Slot Mask

This block turns 32-bit parallel audio words into a time-division-multiplexed serial bit stream. The system clock samples a bit clock and a set of frame-sync sources, and all of them share that clock domain. A frame begins when the selected sync source shows a rising edge on a launch edge of the bit clock. After a programmable bit delay, the block sends a fixed number of slots of a fixed width. A per-slot mask chooses which slots carry audio. Each unmasked slot takes one word from a valid/ready source. A masked slot leaves the line idle and takes no word.

Software sets the slot count, the encoded slot width, the bit order, the launch edge, the first-bit delay, the sync source and the mask. It then moves the unit through a reset step and an enable step. Input words keep their audio left-aligned in the 32-bit container, so the unused low bits are never sent. When an unmasked slot finds no word waiting, the block sends zeros and sets a sticky underrun flag.

Top module: `tdm_tx`

## Requirements
- R1: While `ctl_reset` is 1, or while `ctl_enable` is 0, `sdata_o` and `sden_o` are 0 and `s_ready` stays 0. `ctl_reset` also clears the counters, the held word and `underrun_o`.
- R2: `cfg_sync_sel` = n (1..7) makes the unit follow `sync_i[n-1]`. A frame starts on a launch edge where that input is 1 and was 0 at the previous launch edge. With `cfg_sync_sel` = 0 no frame ever starts, and an unselected source has no effect.
- R3: The first data bit is launched `cfg_bit_delay` launch edges after the frame-start edge. A value of 0 gives left-justified timing: data starts on the frame-start edge. A value of 1 gives I2S timing.
- R4: A frame holds `cfg_slots_m1`+1 slots sent back to back. After the last slot the line is idle (`sden_o`=0, `sdata_o`=0) until the next frame start.
- R5: `cfg_width_code` 4, 8, 12 and 16 select slot widths of 16, 20, 24 and 32 bits. Any other code starts no frame and consumes no word.
- R6: With `cfg_lsb_first`=0, a slot of width W sends word bits 31 down to 32-W. With `cfg_lsb_first`=1 it sends bits 32-W up to 31. Bits below 32-W are never sent.
- R7: With `cfg_bclk_pol`=0, outputs change only one system clock after a rising `bclk_i`. With `cfg_bclk_pol`=1 they change only after a falling `bclk_i`.
- R8: A 1 in bit s of `cfg_slot_mask` makes slot s idle (`sden_o`=0, `sdata_o`=0) and consumes no word. A 0 bit makes the slot hold `sden_o`=1 for all its bits.
- R9: `s_ready` is 1 for one system clock on the launch edge of the first bit of each unmasked slot. The word is taken in that cycle when `s_valid` is 1, so each frame consumes exactly one word per unmasked slot started.
- R10: An unmasked slot that starts with `s_valid`=0 sends all zeros with `sden_o`=1 and sets `underrun_o`. The flag stays set until `ctl_reset`.
- R11: A frame start that arrives while a frame is still running drops the old frame. Slot 0 of the new frame follows at once. This includes a frame start on the edge right after the last bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_enable | input | 1 | Unit enable |
| ctl_reset | input | 1 | Unit soft reset |
| cfg_slots_m1 | input | SLOT_W | Slots per frame minus one |
| cfg_width_code | input | 5 | Encoded slot width |
| cfg_lsb_first | input | 1 | 1: least significant bit first |
| cfg_bclk_pol | input | 1 | 0: launch on rising bit clock, 1: falling |
| cfg_bit_delay | input | DLY_W | Launch edges from frame start to first bit |
| cfg_sync_sel | input | SEL_W | Sync source select, 0 = none |
| cfg_slot_mask | input | SLOT_N | 1 = slot not driven |
| bclk_i | input | 1 | Bit clock, sampled by clk |
| sync_i | input | NSYNC | Frame-sync sources |
| s_valid | input | 1 | Word available |
| s_data | input | 32 | Left-aligned audio word |
| s_ready | output | 1 | Word taken this cycle when s_valid |
| sdata_o | output | 1 | Serial data |
| sden_o | output | 1 | Serial data enable |
| underrun_o | output | 1 | Sticky underrun flag |

## Verification
Two events can land on the same launch edge: a new frame-sync edge, and the slot sequencer moving on (to idle after the last bit, or to the next slot mid-frame along with a word fetch). The bench provokes this with frame periods exactly equal to, and shorter than, the delay plus slots times width. In the shorter case, frame sync returns inside a slot. At that edge it expects slot 0 of the new frame, carrying the next word in sequence. It also checks that the number of words taken equals only the slots that actually started.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;

  localparam int WORD_W = 32;
  localparam int IDX_W  = $clog2(WORD_W);

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_DELAY = 2'd1,
    PH_DATA  = 2'd2
  } phase_e;

  // Slot width in bits for an encoded width field; zero marks an invalid code.
  function automatic logic [IDX_W:0] width_bits(input logic [4:0] code);
    logic [IDX_W:0] w;
    case (code)
      5'd4:    w = (IDX_W+1)'(16);
      5'd8:    w = (IDX_W+1)'(20);
      5'd12:   w = (IDX_W+1)'(24);
      5'd16:   w = (IDX_W+1)'(32);
      default: w = '0;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/tdm_tx_rstsync.sv
module tdm_tx_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok
);

  logic [STAGES-1:0] sync_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[g] <= 1'b0;
        else        sync_q[g] <= 1'b1;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[g] <= 1'b0;
        else        sync_q[g] <= sync_q[g-1];
      end
    end
  end

  assign rst_ok = sync_q[STAGES-1];

endmodule

// File: rtl/tdm_tx_edge.sv
module tdm_tx_edge #(
  parameter int NSYNC = 7,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             clr,
  input  logic             pol,
  input  logic             bclk_i,
  input  logic [NSYNC-1:0] sync_i,
  input  logic [SEL_W-1:0] sync_sel,
  output logic             tick,
  output logic             frame_start
);

  logic bclk_q, bclk_d;
  logic fs_prev_q, fs_prev_d;
  logic fs_cur;

  // launch edge of the sampled bit clock
  always_comb begin
    if (pol) tick = bclk_q & ~bclk_i;
    else     tick = bclk_i & ~bclk_q;
  end

  // sync source selection; code 0 selects nothing
  always_comb begin
    fs_cur = 1'b0;
    for (int i = 0; i < NSYNC; i++) begin
      if (sync_sel == SEL_W'(i + 1)) fs_cur = sync_i[i];
    end
  end

  assign frame_start = tick & fs_cur & ~fs_prev_q;

  always_comb begin
    bclk_d    = bclk_i;
    fs_prev_d = fs_prev_q;
    if (clr)       fs_prev_d = 1'b0;
    else if (tick) fs_prev_d = fs_cur;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      bclk_q    <= 1'b0;
      fs_prev_q <= 1'b0;
    end else begin
      bclk_q    <= bclk_d;
      fs_prev_q <= fs_prev_d;
    end
  end

endmodule

// File: rtl/tdm_tx_seq.sv
module tdm_tx_seq
  import tdm_tx_pkg::*;
#(
  parameter int SLOT_W = 4,
  parameter int DLY_W  = 4
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              live,
  input  logic              tick,
  input  logic              frame_start,
  input  logic              width_ok,
  input  logic [IDX_W:0]    wbits,
  input  logic [SLOT_W-1:0] slots_m1,
  input  logic [DLY_W-1:0]  dly,
  output logic              emit,
  output logic [SLOT_W-1:0] e_slot,
  output logic [IDX_W-1:0]  e_bit
);

  phase_e            phase_q, phase_d;
  logic [DLY_W-1:0]  dly_q, dly_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [IDX_W-1:0]  bit_q, bit_d;
  logic              last_bit;

  assign last_bit = ({1'b0, e_bit} + (IDX_W+1)'(1)) >= wbits;

  always_comb begin
    phase_d = phase_q;
    dly_d   = dly_q;
    slot_d  = slot_q;
    bit_d   = bit_q;
    emit    = 1'b0;
    e_slot  = slot_q;
    e_bit   = bit_q;
    if (!live) begin
      phase_d = PH_IDLE;
      dly_d   = '0;
      slot_d  = '0;
      bit_d   = '0;
    end else if (tick) begin
      if (frame_start && width_ok) begin
        if (dly == '0) begin
          emit   = 1'b1;
          e_slot = '0;
          e_bit  = '0;
        end else begin
          phase_d = PH_DELAY;
          dly_d   = dly - DLY_W'(1);
        end
      end else if (phase_q == PH_DELAY) begin
        if (dly_q == '0) begin
          emit   = 1'b1;
          e_slot = '0;
          e_bit  = '0;
        end else begin
          dly_d = dly_q - DLY_W'(1);
        end
      end else if (phase_q == PH_DATA) begin
        emit = 1'b1;
      end
      if (emit) begin
        if (last_bit) begin
          if (e_slot >= slots_m1) begin
            phase_d = PH_IDLE;
            slot_d  = '0;
            bit_d   = '0;
          end else begin
            phase_d = PH_DATA;
            slot_d  = e_slot + SLOT_W'(1);
            bit_d   = '0;
          end
        end else begin
          phase_d = PH_DATA;
          slot_d  = e_slot;
          bit_d   = e_bit + IDX_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      dly_q   <= '0;
      slot_q  <= '0;
      bit_q   <= '0;
    end else begin
      phase_q <= phase_d;
      dly_q   <= dly_d;
      slot_q  <= slot_d;
      bit_q   <= bit_d;
    end
  end

endmodule

// File: rtl/tdm_tx_out.sv
module tdm_tx_out
  import tdm_tx_pkg::*;
#(
  parameter int SLOT_N = 16,
  parameter int SLOT_W = 4
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              live,
  input  logic              clr,
  input  logic              tick,
  input  logic              emit,
  input  logic [SLOT_W-1:0] e_slot,
  input  logic [IDX_W-1:0]  e_bit,
  input  logic [IDX_W:0]    wbits,
  input  logic              lsb_first,
  input  logic [SLOT_N-1:0] slot_mask,
  input  logic              s_valid,
  input  logic [WORD_W-1:0] s_data,
  output logic              s_ready,
  output logic              sdata_o,
  output logic              sden_o,
  output logic              underrun_o
);

  localparam logic [IDX_W:0]   WORD_FULL = (IDX_W+1)'(WORD_W);
  localparam logic [IDX_W-1:0] TOP_BIT   = IDX_W'(WORD_W - 1);

  logic              slot_on, start_slot, take;
  logic [WORD_W-1:0] word_q, word_d, cur_word, load_word;
  logic [IDX_W:0]    lo_sum;
  logic [IDX_W-1:0]  pick;
  logic              sdata_q, sdata_d, sden_q, sden_d, under_q, under_d;

  assign slot_on    = ~slot_mask[e_slot];
  assign start_slot = emit & (e_bit == '0);
  assign s_ready    = start_slot & slot_on;
  assign take       = s_ready & s_valid;
  assign load_word  = take ? s_data : '0;
  assign cur_word   = start_slot ? load_word : word_q;

  // bit position inside the left-aligned container
  assign lo_sum = WORD_FULL - wbits + {1'b0, e_bit};
  assign pick   = lsb_first ? lo_sum[IDX_W-1:0] : (TOP_BIT - e_bit);

  always_comb begin
    word_d  = word_q;
    sdata_d = sdata_q;
    sden_d  = sden_q;
    if (!live) begin
      word_d  = '0;
      sdata_d = 1'b0;
      sden_d  = 1'b0;
    end else begin
      if (start_slot) word_d = slot_on ? load_word : '0;
      if (tick) begin
        sden_d  = emit & slot_on;
        sdata_d = emit & slot_on & cur_word[pick];
      end
    end
  end

  always_comb begin
    if (clr) under_d = 1'b0;
    else     under_d = under_q | (s_ready & ~s_valid);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q  <= '0;
      sdata_q <= 1'b0;
      sden_q  <= 1'b0;
      under_q <= 1'b0;
    end else begin
      word_q  <= word_d;
      sdata_q <= sdata_d;
      sden_q  <= sden_d;
      under_q <= under_d;
    end
  end

  assign sdata_o    = sdata_q;
  assign sden_o     = sden_q;
  assign underrun_o = under_q;

endmodule

// File: rtl/tdm_tx.sv
module tdm_tx
  import tdm_tx_pkg::*;
#(
  parameter int NSYNC  = 7,
  parameter int SLOT_N = 16,
  parameter int DLY_W  = 4,
  localparam int SEL_W  = $clog2(NSYNC + 1),
  localparam int SLOT_W = $clog2(SLOT_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_enable,
  input  logic              ctl_reset,
  input  logic [SLOT_W-1:0] cfg_slots_m1,
  input  logic [4:0]        cfg_width_code,
  input  logic              cfg_lsb_first,
  input  logic              cfg_bclk_pol,
  input  logic [DLY_W-1:0]  cfg_bit_delay,
  input  logic [SEL_W-1:0]  cfg_sync_sel,
  input  logic [SLOT_N-1:0] cfg_slot_mask,
  input  logic              bclk_i,
  input  logic [NSYNC-1:0]  sync_i,
  input  logic              s_valid,
  input  logic [WORD_W-1:0] s_data,
  output logic              s_ready,
  output logic              sdata_o,
  output logic              sden_o,
  output logic              underrun_o
);

  logic              rst_ok;
  logic              live;
  logic              tick, frame_start;
  logic [IDX_W:0]    wbits;
  logic              width_ok;
  logic              emit;
  logic [SLOT_W-1:0] e_slot;
  logic [IDX_W-1:0]  e_bit;

  assign wbits    = width_bits(cfg_width_code);
  assign width_ok = (wbits != '0);
  assign live     = rst_ok & ctl_enable & ~ctl_reset;

  tdm_tx_rstsync #(.STAGES(2)) u_rstsync (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ok (rst_ok)
  );

  tdm_tx_edge #(.NSYNC(NSYNC), .SEL_W(SEL_W)) u_edge (
    .clk         (clk),
    .rst_ni      (rst_ok),
    .clr         (ctl_reset),
    .pol         (cfg_bclk_pol),
    .bclk_i      (bclk_i),
    .sync_i      (sync_i),
    .sync_sel    (cfg_sync_sel),
    .tick        (tick),
    .frame_start (frame_start)
  );

  tdm_tx_seq #(.SLOT_W(SLOT_W), .DLY_W(DLY_W)) u_seq (
    .clk         (clk),
    .rst_ni      (rst_ok),
    .live        (live),
    .tick        (tick),
    .frame_start (frame_start),
    .width_ok    (width_ok),
    .wbits       (wbits),
    .slots_m1    (cfg_slots_m1),
    .dly         (cfg_bit_delay),
    .emit        (emit),
    .e_slot      (e_slot),
    .e_bit       (e_bit)
  );

  tdm_tx_out #(.SLOT_N(SLOT_N), .SLOT_W(SLOT_W)) u_out (
    .clk        (clk),
    .rst_ni     (rst_ok),
    .live       (live),
    .clr        (ctl_reset),
    .tick       (tick),
    .emit       (emit),
    .e_slot     (e_slot),
    .e_bit      (e_bit),
    .wbits      (wbits),
    .lsb_first  (cfg_lsb_first),
    .slot_mask  (cfg_slot_mask),
    .s_valid    (s_valid),
    .s_data     (s_data),
    .s_ready    (s_ready),
    .sdata_o    (sdata_o),
    .sden_o     (sden_o),
    .underrun_o (underrun_o)
  );

endmodule

// File: rtl/tdm_tx_chk.sv
module tdm_tx_chk #(
  parameter int SLOT_N = 16,
  parameter int SLOT_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ctl_enable,
  input logic              ctl_reset,
  input logic              tick,
  input logic              emit,
  input logic [SLOT_W-1:0] e_slot,
  input logic [4:0]        e_bit_lo,
  input logic [SLOT_N-1:0] cfg_slot_mask,
  input logic              s_ready,
  input logic              s_valid,
  input logic              sdata_o,
  input logic              sden_o,
  input logic              underrun_o
);

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_reset |=> (!sdata_o && !sden_o && !underrun_o)); // R1

  AST_READY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (ctl_enable && !ctl_reset)); // R1

  AST_MASK_NO_PULL: assert property (@(posedge clk) disable iff (!rst_n)
    (emit && (e_bit_lo == 5'd0) && cfg_slot_mask[e_slot]) |-> !s_ready); // R8

  AST_READY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (tick && emit && (e_bit_lo == 5'd0))); // R9

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !ctl_reset && ctl_enable) |=> ($stable(sdata_o) && $stable(sden_o))); // R7

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !sden_o |-> !sdata_o); // R8

  AST_UNDERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ready && !s_valid && !ctl_reset) |=> underrun_o); // R10

  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun_o && !ctl_reset) |=> underrun_o); // R10

endmodule

bind tdm_tx tdm_tx_chk #(.SLOT_N(SLOT_N), .SLOT_W(SLOT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ctl_enable    (ctl_enable),
  .ctl_reset     (ctl_reset),
  .tick          (tick),
  .emit          (emit),
  .e_slot        (e_slot),
  .e_bit_lo      (e_bit),
  .cfg_slot_mask (cfg_slot_mask),
  .s_ready       (s_ready),
  .s_valid       (s_valid),
  .sdata_o       (sdata_o),
  .sden_o        (sden_o),
  .underrun_o    (underrun_o)
);

// File: tb/tdm_tx_tb.sv
module tdm_tx_tb;

  localparam int HALF = 4;

  logic        clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n;
  logic        ctl_enable, ctl_reset;
  logic [3:0]  cfg_slots_m1;
  logic [4:0]  cfg_width_code;
  logic        cfg_lsb_first, cfg_bclk_pol;
  logic [3:0]  cfg_bit_delay;
  logic [2:0]  cfg_sync_sel;
  logic [15:0] cfg_slot_mask;
  logic        bclk_i;
  logic [6:0]  sync_i;
  logic        s_valid;
  logic [31:0] s_data;
  logic        s_ready, sdata_o, sden_o, underrun_o;

  int          checks = 0;
  int          errors = 0;
  int          idx;
  logic [31:0] data_base = 32'h1F2E3D4C;
  bit          last_d, last_e;
  bit          ur_exp;

  function automatic logic [31:0] sample(input int i);
    logic [31:0] v;
    v = data_base ^ (32'(i) * 32'h9E3779B1);
    return {v[15:0], v[31:16]} ^ 32'(i);
  endfunction

  function automatic int wbits(input logic [4:0] c);
    case (c)
      5'd4:    return 16;
      5'd8:    return 20;
      5'd12:   return 24;
      5'd16:   return 32;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx <= 0;
    else if (s_ready && s_valid) idx <= idx + 1;
  end

  assign s_data = sample(idx);

  tdm_tx u_dut (
    .clk (clk), .rst_n (rst_n), .ctl_enable (ctl_enable), .ctl_reset (ctl_reset),
    .cfg_slots_m1 (cfg_slots_m1), .cfg_width_code (cfg_width_code),
    .cfg_lsb_first (cfg_lsb_first), .cfg_bclk_pol (cfg_bclk_pol),
    .cfg_bit_delay (cfg_bit_delay), .cfg_sync_sel (cfg_sync_sel),
    .cfg_slot_mask (cfg_slot_mask), .bclk_i (bclk_i), .sync_i (sync_i),
    .s_valid (s_valid), .s_data (s_data), .s_ready (s_ready),
    .sdata_o (sdata_o), .sden_o (sden_o), .underrun_o (underrun_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                     input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_up;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // One bit-clock period: non-launch half, then launch edge with frame sync.
  task automatic bit_time(input bit fs, input int src, input bit hold_chk,
                          output bit od, output bit oe);
    bit lv;
    lv = !cfg_bclk_pol;
    @(negedge clk);
    bclk_i = !lv;
    repeat (HALF-1) @(negedge clk);
    if (hold_chk) chk("R7", {30'd0, sden_o, sdata_o}, {30'd0, last_e, last_d},
                      "outputs held off the launch edge");
    @(negedge clk);
    bclk_i = lv;
    sync_i = '0;
    if (fs && src > 0) sync_i[src-1] = 1'b1;
    repeat (2) @(negedge clk);
    od = sdata_o;
    oe = sden_o;
    last_d = od;
    last_e = oe;
    repeat (HALF-3) @(negedge clk);
  endtask

  task automatic setup(input bit en, input int sm1, input int code, input bit lsb,
                       input bit pol, input int dly, input int sel, input logic [15:0] mask);
    bit d0, e0;
    ctl_enable = 1'b0;
    bit_time(1'b0, 0, 1'b0, d0, e0);
    cfg_slots_m1   = 4'(sm1);
    cfg_width_code = 5'(code);
    cfg_lsb_first  = lsb;
    cfg_bclk_pol   = pol;
    cfg_bit_delay  = 4'(dly);
    cfg_sync_sel   = 3'(sel);
    cfg_slot_mask  = mask;
    ctl_enable     = en;
    bit_time(1'b0, 0, 1'b0, d0, e0);
    bit_time(1'b0, 0, 1'b1, d0, e0);
  endtask

  function automatic logic [1:0] exp_out(input int t, input int f, input int base,
                                         input int cons, input int w, input int s_n,
                                         input int d, input bit valid);
    int k, s, b, n;
    logic [31:0] word;
    bit bv;
    if (t < d) return 2'b00;
    k = t - d;
    s = k / w;
    b = k % w;
    if (s >= s_n) return 2'b00;
    if (cfg_slot_mask[s]) return 2'b00;
    n = base + f * cons;
    for (int j = 0; j < s; j++) if (!cfg_slot_mask[j]) n++;
    word = valid ? sample(n) : 32'd0;
    bv = cfg_lsb_first ? word[32 - w + b] : word[31 - b];
    return {1'b1, bv};
  endfunction

  task automatic run_case(input string tag, input int nframes, input int flen,
                          input int src, input bit valid);
    int w, s_n, d, cons, base;
    bit active, od, oe;
    logic [1:0] e;
    s_valid = valid;
    w   = wbits(cfg_width_code);
    s_n = int'(cfg_slots_m1) + 1;
    d   = int'(cfg_bit_delay);
    active = ctl_enable && !ctl_reset && (w != 0) && (cfg_sync_sel != 3'd0)
             && (int'(cfg_sync_sel) == src);
    cons = 0;
    if (w != 0)
      for (int s = 0; s < s_n; s++)
        if (!cfg_slot_mask[s] && (d + s * w < flen)) cons++;
    base = idx;
    for (int f = 0; f < nframes; f++) begin
      for (int t = 0; t < flen; t++) begin
        bit_time(t == 0, src, 1'b1, od, oe);
        e = active ? exp_out(t, f, base, cons, w, s_n, d, valid) : 2'b00;
        chk(tag, {30'd0, oe, od}, {30'd0, e}, $sformatf("frame %0d bit %0d", f, t));
      end
    end
    chk("R9", 32'(idx), 32'(base + ((active && valid) ? nframes * cons : 0)),
        "words consumed");
    if (active && !valid && cons > 0) ur_exp = 1'b1;
    chk("R10", {31'd0, underrun_o}, {31'd0, ur_exp}, "underrun flag");
    s_valid = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete");
    finish_up();
  end

  initial begin
    bit d0, e0;
    int code, sm1, dly, w;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; ctl_enable = 1'b0; ctl_reset = 1'b0;
    cfg_slots_m1 = '0; cfg_width_code = 5'd4; cfg_lsb_first = 1'b0;
    cfg_bclk_pol = 1'b0; cfg_bit_delay = '0; cfg_sync_sel = '0; cfg_slot_mask = '0;
    bclk_i = 1'b0; sync_i = '0; s_valid = 1'b1; ur_exp = 1'b0;
    last_d = 1'b0; last_e = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", {28'd0, sdata_o, sden_o, underrun_o, s_ready}, 32'd0, "state after reset");

    // reset then enable sequence, I2S timing, MSB first, rising launch
    ctl_reset = 1'b1;
    bit_time(1'b0, 0, 1'b0, d0, e0);
    ctl_reset = 1'b0;
    setup(1, 1, 4, 0, 0, 1, 1, 16'h0000);
    run_case("R3", 2, 40, 1, 1'b1);

    // left-justified, 20-bit, LSB first, falling launch
    setup(1, 1, 8, 1, 1, 0, 2, 16'h0000);
    run_case("R6", 2, 44, 2, 1'b1);

    // 24-bit with a masked middle slot
    setup(1, 2, 12, 0, 1, 1, 1, 16'h0002);
    run_case("R8", 2, 80, 1, 1'b1);

    // 32-bit, sixteen slots, sparse mask, idle tail
    setup(1, 15, 16, 1, 0, 2, 4, 16'hA5C3);
    run_case("R4", 1, 520, 4, 1'b1);

    // single slot, longer delay
    setup(1, 0, 4, 0, 0, 3, 1, 16'h0000);
    run_case("R3", 2, 24, 1, 1'b1);

    // invalid width codes start nothing
    setup(1, 1, 5, 0, 0, 1, 1, 16'h0000);
    run_case("R5", 1, 40, 1, 1'b1);
    setup(1, 1, 20, 0, 0, 0, 1, 16'h0000);
    run_case("R5", 1, 40, 1, 1'b1);

    // sync selection: none, wrong source, highest source
    setup(1, 1, 4, 0, 0, 1, 0, 16'h0000);
    run_case("R2", 1, 40, 1, 1'b1);
    setup(1, 1, 4, 0, 0, 1, 3, 16'h0000);
    run_case("R2", 1, 40, 2, 1'b1);
    setup(1, 1, 4, 0, 0, 1, 7, 16'h0000);
    run_case("R2", 2, 40, 7, 1'b1);

    // frame sync on the edge right after the last bit, then inside a slot
    setup(1, 1, 4, 0, 0, 1, 1, 16'h0000);
    run_case("R11", 3, 33, 1, 1'b1);
    setup(1, 2, 4, 1, 1, 0, 1, 16'h0001);
    run_case("R11", 3, 27, 1, 1'b1);

    // disabled unit stays idle and takes nothing
    setup(0, 1, 4, 0, 0, 1, 1, 16'h0000);
    run_case("R1", 1, 40, 1, 1'b1);

    // held in reset: idle and nothing taken
    setup(1, 1, 4, 0, 0, 1, 1, 16'h0000);
    ctl_reset = 1'b1;
    bit_time(1'b0, 0, 1'b0, d0, e0);
    run_case("R1", 1, 40, 1, 1'b1);
    ctl_reset = 1'b0;

    // underrun: zeros with enable high, sticky flag
    setup(1, 1, 8, 0, 0, 1, 1, 16'h0000);
    run_case("R10", 1, 48, 1, 1'b0);
    setup(1, 1, 8, 0, 0, 1, 1, 16'h0003);
    run_case("R10", 1, 48, 1, 1'b0);
    chk("R10", {31'd0, underrun_o}, 32'd1, "flag kept across masked frame");
    ctl_reset = 1'b1;
    bit_time(1'b0, 0, 1'b0, d0, e0);
    chk("R1", {29'd0, underrun_o, sden_o, sdata_o}, 32'd0, "soft reset clears flag");
    ur_exp = 1'b0;
    ctl_reset = 1'b0;

    // constrained random configurations
    for (int i = 0; i < 10; i++) begin
      code = 4 * (int'($urandom_range(3, 0)) + 1);
      sm1  = int'($urandom_range(3, 0));
      dly  = int'($urandom_range(3, 0));
      w    = wbits(5'(code));
      data_base = $urandom;
      setup(1, sm1, code, 1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)), dly,
            int'($urandom_range(7, 1)), 16'($urandom));
      run_case("R4", 2, dly + (sm1 + 1) * w + int'($urandom_range(3, 0)),
               int'(cfg_sync_sel), 1'b1);
    end

    finish_up();
  end

endmodule